// File: doc/BRIEF.md
# Clear-on-read video interrupt status collector

This block collects per-channel video DMA events into a single 32-bit interrupt status word that a host fetches over a simple register bus. Each channel raises two kinds of one-cycle pulse: a frame-done pulse and an error pulse. Done events land in the low byte lane of the word and error events land in the top byte lane. A bit stays set until the host reads the status word. That read returns the bits and clears them in the same cycle. An event that arrives in the cycle of the read is kept for the next read.

Next to the status word the block keeps a ping-pong word. It records, for each channel, which of its two buffer tables the most recent frame-done event completed. A host-writable enable mask gates the status bits onto one level interrupt line. The line can be shared, so it is high only while an enabled status bit is pending. The channel count is a build parameter, either 4 or 8. Lanes of channels that are not built read as zero.

Top module: `irqStatCollector`

## Requirements
- R1: After reset the status word and the ping-pong word read 0, the enable mask reads all implemented lane bits set (0xFF0000FF for 8 channels), and `irq` is low.
- R2: A pulse on `doneEvt[i]` sets status bit i and a pulse on `errEvt[i]` sets status bit 24+i. Both take effect at the next clock edge. Set bits accumulate until the status word is read. Bits 8..23, and the bits of channels that are not built, always read 0.
- R3: A read of offset 0 returns the status word and clears it at that clock edge. With no new events in between, the next read returns 0.
- R4: An event pulse in the same cycle as a status read does not appear in that read's data. Its bit is set in the cleared word, so the following read returns it.
- R5: The ping-pong word at offset 1 holds one bit per channel. On `doneEvt[i]`, bit i takes the value of `tblSel[i]` (0 = table 0, 1 = table 1). Error pulses, reads of any register and writes do not change it.
- R6: `irq` is high exactly when some status bit is set together with its enable-mask bit. It follows the registered state, one clock edge after the event, read or mask write that changes it.
- R7: The enable mask at offset 2 is read/write. Only implemented lane bits (bits 0..N-1 and 24..24+N-1) are stored. The other bits read 0.
- R8: Reads of offsets other than 0, 1 and 2 return 0 and change no state. Writes to offsets 0 and 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| doneEvt | input | NUM_CH | Per-channel frame-done pulses |
| errEvt | input | NUM_CH | Per-channel error pulses |
| tblSel | input | NUM_CH | Buffer table completed, qualified by doneEvt |
| rdEn | input | 1 | Register read strobe |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register word offset |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, combinational in the read cycle |
| irq | output | 1 | Level interrupt request |

## Verification
The clear that a status read causes and the setting of a bit by an event can happen in the same clock cycle. The bench provokes this by asserting a done pulse while the read strobe is active on offset 0. It then judges two things: the returned data must hold only the bits pending before that cycle, and the following read must return exactly the bit of the colliding event. The same overlap is also exercised with bits pending on other channels, so a design that drops the event or merges it into the current read is caught.

// File: rtl/irqStatPkg.sv
package irqStatPkg;
  localparam int ERR_LANE  = 24;
  localparam int STAT_OFS  = 0;
  localparam int PING_OFS  = 1;
  localparam int MASK_OFS  = 2;

  typedef struct packed {
    logic rdStatus;
    logic rdPing;
    logic rdMask;
    logic wrMask;
  } hostStrb_t;
endpackage

// File: rtl/irqHostDecode.sv
module irqHostDecode
  import irqStatPkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output hostStrb_t         strb
);
  always_comb begin
    strb          = '0;
    strb.rdStatus = rdEn && (addr == ADDR_W'(STAT_OFS));
    strb.rdPing   = rdEn && (addr == ADDR_W'(PING_OFS));
    strb.rdMask   = rdEn && (addr == ADDR_W'(MASK_OFS));
    strb.wrMask   = wrEn && (addr == ADDR_W'(MASK_OFS));
  end

  // R8: at most one read target is selected per cycle
  one_read_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.rdStatus, strb.rdPing, strb.rdMask}));
endmodule

// File: rtl/irqStatCore.sv
module irqStatCore
  import irqStatPkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  hostStrb_t         strb,
  input  logic [NUM_CH-1:0] doneEvt,
  input  logic [NUM_CH-1:0] errEvt,
  input  logic [NUM_CH-1:0] tblSel,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic              irq
);
  localparam logic [31:0] CH_BITS   = (32'd1 << NUM_CH) - 32'd1;
  localparam logic [31:0] LANE_MASK = (CH_BITS << ERR_LANE) | CH_BITS;

  logic [31:0]       evtWord;
  logic [31:0]       statusQ;
  logic [31:0]       maskQ;
  logic [NUM_CH-1:0] pingQ;

  always_comb begin
    evtWord = '0;
    evtWord[NUM_CH-1:0]         = doneEvt;
    evtWord[ERR_LANE +: NUM_CH] = errEvt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= (strb.rdStatus ? 32'd0 : statusQ) | evtWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            maskQ <= LANE_MASK;
    else if (strb.wrMask) maskQ <= wrData & LANE_MASK;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ping
    always_ff @(posedge clk) begin
      if (!rstN)           pingQ[i] <= 1'b0;
      else if (doneEvt[i]) pingQ[i] <= tblSel[i];
    end
  end

  always_comb begin
    rdData = '0;
    if (strb.rdStatus)    rdData = statusQ;
    else if (strb.rdPing) rdData = 32'(pingQ);
    else if (strb.rdMask) rdData = maskQ;
  end

  assign irq = |(statusQ & maskQ);

  // R3
  read_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdStatus && evtWord == 32'd0) |=> statusQ == 32'd0);

  // R2
  event_captured_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtWord != 32'd0) |=> ((statusQ & $past(evtWord)) == $past(evtWord)));

  // R8
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.rdStatus && evtWord == 32'd0) |=> $stable(statusQ));

  // R5
  ping_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneEvt == '0) |=> $stable(pingQ));

  // R6
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> ($past(evtWord) != 32'd0 || $past(strb.wrMask)));
endmodule

// File: rtl/irqStatCollector.sv
module irqStatCollector
  import irqStatPkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] doneEvt,
  input  logic [NUM_CH-1:0] errEvt,
  input  logic [NUM_CH-1:0] tblSel,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic              irq
);
  hostStrb_t strb;

  irqHostDecode #(.ADDR_W(ADDR_W)) u_decode (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn), .addr(addr), .strb(strb)
  );

  irqStatCore #(.NUM_CH(NUM_CH)) u_core (
    .clk(clk), .rstN(rstN), .strb(strb), .doneEvt(doneEvt), .errEvt(errEvt),
    .tblSel(tblSel), .wrData(wrData), .rdData(rdData), .irq(irq)
  );
endmodule

// File: tb/irqStatCollector_tb.sv
module irqStatCollector_tb;
  localparam int N = 8;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] doneEvt = '0, errEvt = '0, tblSel = '0;
  logic rdEn = 1'b0, wrEn = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic irq;
  int checks = 0, errors = 0;
  logic [31:0] v;
  logic [7:0] pingExp = '0;

  always #4 clk = ~clk;

  irqStatCollector #(.NUM_CH(N), .ADDR_W(4)) u_dut (
    .clk(clk), .rstN(rstN), .doneEvt(doneEvt), .errEvt(errEvt), .tblSel(tblSel),
    .rdEn(rdEn), .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [7:0] d, input logic [7:0] e, input logic [7:0] t);
    @(negedge clk); doneEvt = d; errEvt = e; tblSel = t;
    @(negedge clk); doneEvt = '0; errEvt = '0; tblSel = '0;
    pingExp = (pingExp & ~d) | (t & d);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] val);
    @(negedge clk); rdEn = 1'b1; addr = a;
    #1 val = rdData;
    @(negedge clk); rdEn = 1'b0; addr = '0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0; addr = '0; wrData = '0;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk("R1 irq", 32'(irq), 32'd0);
    rd(4'd0, v); chk("R1 status", v, 32'd0);
    rd(4'd1, v); chk("R1 ping", v, 32'd0);
    rd(4'd2, v); chk("R1 mask", v, 32'hFF0000FF);

    // R2 R3 R5 R6 per-channel sweep
    for (int ch = 0; ch < N; ch++) begin
      pulse(8'(1 << ch), 8'h00, 8'(ch[0] << ch));
      chk("R6 irq after done", 32'(irq), 32'd1);
      rd(4'd0, v); chk("R2 done bit", v, 32'd1 << ch);
      chk("R6 irq after read", 32'(irq), 32'd0);
      rd(4'd0, v); chk("R3 cleared", v, 32'd0);
      pulse(8'h00, 8'(1 << ch), 8'hFF);
      rd(4'd1, v); chk("R5 ping untouched by error", v, 32'(pingExp));
      rd(4'd0, v); chk("R2 error bit", v, 32'd1 << (24 + ch));
    end

    // R2 R5 pattern sweep with accumulation
    for (int k = 0; k < 16; k++) begin
      logic [7:0] d1, e1, t1, d2;
      d1 = 8'((k * 37 + 11) & 255); e1 = 8'((k * 91 + 5) & 255);
      t1 = 8'((k * 53) & 255);      d2 = 8'((k * 29 + 3) & 255);
      pulse(d1, e1, t1);
      pulse(d2, 8'h00, ~t1);
      rd(4'd0, v); chk("R2 accumulate", v, {e1, 16'h0000, d1 | d2});
      rd(4'd1, v); chk("R5 ping pattern", v, 32'(pingExp));
    end

    // R4 read and event in the same cycle
    pulse(8'h04, 8'h00, 8'h00);
    @(negedge clk); rdEn = 1'b1; addr = 4'd0; doneEvt = 8'h20; tblSel = 8'h20;
    #1 v = rdData;
    @(negedge clk); rdEn = 1'b0; doneEvt = '0; tblSel = '0;
    pingExp = (pingExp & ~8'h24) | 8'h20;
    chk("R4 read data excludes new event", v, 32'h0000_0004);
    chk("R4 irq kept", 32'(irq), 32'd1);
    rd(4'd0, v); chk("R4 event kept", v, 32'h0000_0020);
    rd(4'd1, v); chk("R5 ping after overlap", v, 32'(pingExp));

    // R7 R6 mask
    wr(4'd2, 32'h0000_0000);
    rd(4'd2, v); chk("R7 mask zero", v, 32'd0);
    pulse(8'h01, 8'h80, 8'h00);
    chk("R6 masked irq low", 32'(irq), 32'd0);
    wr(4'd2, 32'hFFFF_FFFF);
    rd(4'd2, v); chk("R7 only lane bits", v, 32'hFF0000FF);
    chk("R6 irq after unmask", 32'(irq), 32'd1);
    wr(4'd2, 32'h8000_0000);
    chk("R6 error lane enabled", 32'(irq), 32'd1);
    wr(4'd2, 32'h0000_0002);
    chk("R6 other lane only", 32'(irq), 32'd0);
    wr(4'd2, 32'hFF0000FF);

    // R8 unmapped reads and ignored writes
    for (int a = 3; a < 16; a++) begin
      rd(4'(a), v); chk("R8 unmapped read zero", v, 32'd0);
    end
    wr(4'd0, 32'h0000_0000);
    wr(4'd1, 32'hFFFF_FFFF);
    rd(4'd1, v); chk("R8 ping write ignored", v, 32'(pingExp));
    rd(4'd0, v); chk("R8 status kept", v, 32'h8000_0001);
    rd(4'd0, v); chk("R3 final clear", v, 32'd0);
    chk("R6 final irq", 32'(irq), 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule